// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the register port of a digital audio receiver. A host microcontroller reaches it over four wires: a chip enable, a serial clock, a data line into the block and a data line out of it. All four are sampled in the block's own system clock domain through two-flop synchronisers, so the serial clock must run well below the system clock, with each half period lasting at least four system clocks. Every transaction is framed by chip enable. The first eight bits are an address code that picks either a write of a 16-bit control word or a read of a 16-bit status word. Bits travel least significant first and are taken on rising edges of the serial clock.

Written settings drive three source selectors. Each picks one of six receiver inputs, or a constant low. The first selector feeds the demodulator and the other two feed two pass-through outputs. One further written bit picks the audio output format. The status word reports the sample-rate code, the copy permission, the first channel-status bit and the category code. These values arrive on input ports and are held in a status register. That register is forced to a fixed cleared pattern whenever the receiver is not locked.

Top module: `ctl_serial_port`

## Requirements
- R1: The first eight bits after chip enable rises form an address code, with the first bit in bit 0. Code 8'h65 opens a write and code 8'h66 opens a read. Any other code makes the rest of the transaction have no effect on the settings, and `ser_dout` stays low.
- R2: In a write, data bit k is the k-th bit after the address. Bits 5..7 set `demod_sel`, bits 8..10 set `pass1_sel` and bits 11..13 set `pass2_sel`, each with its lowest bit first. Bits 0..4 and bit 15 have no effect.
- R3: A write takes effect only when chip enable falls after exactly 16 data bits. A transfer with fewer or more data bits leaves all settings unchanged, and settings never change outside such a commit.
- R4: Each selector code c from 0 to 5 routes `src_in[c]` to its output. Codes 6 and 7 drive the output low.
- R5: Write bit 14 sets `fmt_lsb20`: 0 selects 16-bit MSB-first output and 1 selects 20-bit LSB-first output.
- R6: A read returns 16 bits, bit 0 first, each valid on `ser_dout` before the rising serial clock edge that ends it. Bits 0, 13, 14 and 15 are 0. Bit 3 is `st_copy` (1 means copying allowed). Bit 4 is `st_cs0`. Bits 5..12 are `st_cat`, with its lowest bit at bit 5.
- R7: Read bits 1 and 2 carry `st_rate[0]` and `st_rate[1]`. The pairs 1/1, 0/0 and 0/1 mean 32 kHz, 44.1 kHz and 48 kHz. The pair 1/0 means cleared.
- R8: While `locked` is low the status word reads 16'h0002: all fields are zero except the rate pair, which shows the cleared code 1/0.
- R9: After reset every setting is 0 and the status word reads 16'h0002.
- R10: `ser_dout` is low whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Serial chip enable, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| src_in | input | 6 | Receiver input lines |
| locked | input | 1 | Receiver lock indication |
| st_rate | input | 2 | Sample-rate code, bit 0 to read bit 1 |
| st_copy | input | 1 | Copy permission flag |
| st_cs0 | input | 1 | First channel-status bit |
| st_cat | input | 8 | Channel-status category code |
| demod_in | output | 1 | Selected demodulator input |
| pass1_out | output | 1 | Pass-through output 1 |
| pass2_out | output | 1 | Pass-through output 2 |
| demod_sel | output | 3 | Demodulator source code |
| pass1_sel | output | 3 | Pass-through 1 source code |
| pass2_sel | output | 3 | Pass-through 2 source code |
| fmt_lsb20 | output | 1 | Audio format select |

## Verification
A bit counter or framing state that slips shows up at once as a setting that holds the wrong field, or that changes after a transfer of the wrong length. The selector codes and the mux outputs show this within a few system clocks of chip enable falling. A wrong address decode appears either as `ser_dout` toggling outside a read or as a read word shifted by one position, and this is visible from the first data bit. A status register that fails to clear shows a non-cleared rate pair on the first read after lock drops.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   localparam logic [7:0]  ADDR_WR     = 8'h65;
   localparam logic [7:0]  ADDR_RD     = 8'h66;
   localparam logic [15:0] STAT_CLEAR  = 16'h0002;

   typedef enum logic [2:0] {
      M_IDLE,
      M_ADDR,
      M_WR,
      M_RD,
      M_SKIP
   } frame_mode_t;

   function automatic logic [15:0] pack_status(input logic [1:0] rate,
                                               input logic       copy,
                                               input logic       cs0,
                                               input logic [7:0] cat);
      return {3'b000, cat, cs0, copy, rate[1], rate[0], 1'b0};
   endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("ctl_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_frame.sv
module ctl_frame
   import ctl_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int FIELD_LO = 5,
   parameter int FIELD_W  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_en,
   input  logic               s_clk,
   input  logic               s_din,
   input  logic [DATA_W-1:0]  stat_word,
   output logic               commit,
   output logic [FIELD_W-1:0] field_q,
   output logic               dout
);
   localparam int CNT_MAX = ADDR_W + DATA_W + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int FI_W    = $clog2(FIELD_W);

   generate
      if (FIELD_LO + FIELD_W > DATA_W) begin : g_bad
         $error("field range exceeds data word");
      end
   endgenerate

   frame_mode_t        mode;
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  addr_sh;
   logic [DATA_W-1:0]  out_sh;
   logic               clk_d, en_d;
   logic               rise, ce_rise, ce_fall;
   logic [CNT_W-1:0]   didx;
   logic               in_field;
   logic [FI_W-1:0]    fidx;

   assign rise    = s_en & s_clk & ~clk_d;
   assign ce_rise = s_en & ~en_d;
   assign ce_fall = en_d & ~s_en;

   always_comb begin
      didx     = cnt - CNT_W'(ADDR_W);
      in_field = (cnt >= CNT_W'(ADDR_W)) &&
                 (didx >= CNT_W'(FIELD_LO)) &&
                 (didx <  CNT_W'(FIELD_LO + FIELD_W));
      fidx     = FI_W'(didx - CNT_W'(FIELD_LO));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= M_IDLE;
         cnt     <= '0;
         addr_sh <= '0;
         out_sh  <= '0;
         field_q <= '0;
         clk_d   <= 1'b0;
         en_d    <= 1'b0;
      end else begin
         clk_d <= s_clk;
         en_d  <= s_en;
         if (ce_rise) begin
            mode <= M_ADDR;
            cnt  <= '0;
         end else if (ce_fall) begin
            mode <= M_IDLE;
         end else if (mode == M_ADDR && cnt == CNT_W'(ADDR_W)) begin
            if (addr_sh == ADDR_WR) begin
               mode <= M_WR;
            end else if (addr_sh == ADDR_RD) begin
               mode   <= M_RD;
               out_sh <= stat_word;
            end else begin
               mode <= M_SKIP;
            end
         end else if (rise) begin
            if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            if (mode == M_ADDR) addr_sh <= {s_din, addr_sh[ADDR_W-1:1]};
            if (mode == M_WR && in_field) field_q[fidx] <= s_din;
            if (mode == M_RD) out_sh <= {1'b0, out_sh[DATA_W-1:1]};
         end
      end
   end

   assign commit = ce_fall && (mode == M_WR) && (cnt == CNT_W'(ADDR_W + DATA_W));
   assign dout   = (mode == M_RD) & out_sh[0];
endmodule

// File: rtl/ctl_src_mux.sv
module ctl_src_mux #(
   parameter int N_SRC = 6,
   parameter int SEL_W = 3
) (
   input  logic [N_SRC-1:0] src,
   input  logic [SEL_W-1:0] sel,
   output logic             y
);
   localparam int N_PAD = 1 << SEL_W;

   logic [N_PAD-1:0] padded;

   generate
      if (N_SRC > N_PAD) begin : g_bad
         $error("selector too narrow for source count");
      end else if (N_SRC == N_PAD) begin : g_full
         assign padded = src;
      end else begin : g_pad
         assign padded = {{(N_PAD-N_SRC){1'b0}}, src};
      end
   endgenerate

   assign y = padded[sel];
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
   import ctl_pkg::*;
#(
   parameter int N_SRC    = 6,
   parameter int SEL_W    = 3,
   parameter int N_MUX    = 3,
   parameter int FIELD_LO = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_en,
   input  logic             ser_clk,
   input  logic             ser_din,
   output logic             ser_dout,
   input  logic [N_SRC-1:0] src_in,
   input  logic             locked,
   input  logic [1:0]       st_rate,
   input  logic             st_copy,
   input  logic             st_cs0,
   input  logic [7:0]       st_cat,
   output logic             demod_in,
   output logic             pass1_out,
   output logic             pass2_out,
   output logic [SEL_W-1:0] demod_sel,
   output logic [SEL_W-1:0] pass1_sel,
   output logic [SEL_W-1:0] pass2_sel,
   output logic             fmt_lsb20
);
   localparam int FIELD_W = N_MUX * SEL_W + 1;
   localparam int DATA_W  = 16;

   generate
      if (N_MUX != 3) begin : g_bad_mux
         $error("port has exactly three selectors");
      end
      if (FIELD_LO + FIELD_W > DATA_W) begin : g_bad_fld
         $error("settings do not fit the write word");
      end
   endgenerate

   logic [2:0]         s_bus;
   logic [DATA_W-1:0]  stat_q;
   logic               commit;
   logic [FIELD_W-1:0] field_q;
   logic [FIELD_W-1:0] set_q;
   logic [N_MUX-1:0]   mux_y;

   ctl_sync #(.W(3), .STAGES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_din, ser_clk, ser_en}),
      .q     (s_bus)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_q <= STAT_CLEAR;
      else if (!locked) stat_q <= STAT_CLEAR;
      else              stat_q <= pack_status(st_rate, st_copy, st_cs0, st_cat);
   end

   ctl_frame #(
      .ADDR_W   (8),
      .DATA_W   (DATA_W),
      .FIELD_LO (FIELD_LO),
      .FIELD_W  (FIELD_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_en      (s_bus[0]),
      .s_clk     (s_bus[1]),
      .s_din     (s_bus[2]),
      .stat_word (stat_q),
      .commit    (commit),
      .field_q   (field_q),
      .dout      (ser_dout)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      set_q <= '0;
      else if (commit) set_q <= field_q;
   end

   generate
      for (genvar m = 0; m < N_MUX; m++) begin : g_mux
         ctl_src_mux #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_mux (
            .src (src_in),
            .sel (set_q[m*SEL_W +: SEL_W]),
            .y   (mux_y[m])
         );
      end
   endgenerate

   assign demod_sel = set_q[0*SEL_W +: SEL_W];
   assign pass1_sel = set_q[1*SEL_W +: SEL_W];
   assign pass2_sel = set_q[2*SEL_W +: SEL_W];
   assign fmt_lsb20 = set_q[FIELD_W-1];
   assign demod_in  = mux_y[0];
   assign pass1_out = mux_y[1];
   assign pass2_out = mux_y[2];
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk #(
   parameter int N_SRC = 6,
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_en,
   input logic             ser_dout,
   input logic             locked,
   input logic             commit,
   input logic [15:0]      stat_q,
   input logic             demod_in,
   input logic             pass1_out,
   input logic [SEL_W-1:0] demod_sel,
   input logic [SEL_W-1:0] pass1_sel,
   input logic [SEL_W-1:0] pass2_sel,
   input logic             fmt_lsb20
);
   AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({fmt_lsb20, pass2_sel, pass1_sel, demod_sel})); // R3

   AST_DEMOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (demod_sel >= SEL_W'(N_SRC)) |-> !demod_in); // R4

   AST_PASS1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pass1_sel >= SEL_W'(N_SRC)) |-> !pass1_out); // R4

   AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_en && !$past(ser_en) && !$past(ser_en, 2) && !$past(ser_en, 3)
       && !$past(ser_en, 4)) |-> !ser_dout); // R10

   AST_UNLOCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> (stat_q == 16'h0002)); // R8
endmodule

bind ctl_serial_port ctl_serial_port_chk #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ser_en    (ser_en),
   .ser_dout  (ser_dout),
   .locked    (locked),
   .commit    (commit),
   .stat_q    (stat_q),
   .demod_in  (demod_in),
   .pass1_out (pass1_out),
   .demod_sel (demod_sel),
   .pass1_sel (pass1_sel),
   .pass2_sel (pass2_sel),
   .fmt_lsb20 (fmt_lsb20)
);

// File: tb/sim_ctl_serial_port.sv
`timescale 1ns/1ps
module sim_ctl_serial_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
   logic       ser_dout;
   logic [5:0] src_in = '0;
   logic       locked = 1'b0;
   logic [1:0] st_rate = '0;
   logic       st_copy = 1'b0, st_cs0 = 1'b0;
   logic [7:0] st_cat = '0;
   logic       demod_in, pass1_out, pass2_out, fmt_lsb20;
   logic [2:0] demod_sel, pass1_sel, pass2_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   ctl_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .ser_din(ser_din), .ser_dout(ser_dout), .src_in(src_in),
      .locked(locked), .st_rate(st_rate), .st_copy(st_copy),
      .st_cs0(st_cs0), .st_cat(st_cat), .demod_in(demod_in),
      .pass1_out(pass1_out), .pass2_out(pass2_out), .demod_sel(demod_sel),
      .pass1_sel(pass1_sel), .pass2_sel(pass2_sel), .fmt_lsb20(fmt_lsb20)
   );

   // {write word, expected {fmt, pass2, pass1, demod}}
   localparam logic [25:0] VEC [4] = '{
      {16'h1100, 10'b0_010_001_000},
      {16'hFEBF, 10'b1_111_110_101},
      {16'h4460, 10'b1_000_100_011},
      {16'h2AE0, 10'b0_101_010_111}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic pick(input logic [5:0] s, input logic [2:0] c);
      return (c < 3'd6) ? s[c] : 1'b0;
   endfunction

   function automatic logic [15:0] stat_exp(input logic [1:0] r, input logic cp,
                                            input logic c0, input logic [7:0] ct);
      logic [15:0] w;
      w       = '0;
      w[1]    = r[0];
      w[2]    = r[1];
      w[3]    = cp;
      w[4]    = c0;
      w[12:5] = ct;
      return w;
   endfunction

   task automatic send_bit(input logic b, output logic s);
      ser_din = b;
      repeat (4) @(negedge clk);
      s = ser_dout;
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] a, input logic [15:0] d, input int nd,
                       output logic [15:0] rd);
      logic s;
      rd = '0;
      @(negedge clk);
      ser_en = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 8; i++) send_bit(a[i], s);
      for (int i = 0; i < nd; i++) begin
         send_bit(d[i % 16], s);
         if (i < 16) rd[i] = s;
      end
      repeat (4) @(negedge clk);
      ser_en = 1'b0;
      repeat (10) @(negedge clk);
   endtask

   function automatic logic [9:0] settings();
      return {fmt_lsb20, pass2_sel, pass1_sel, demod_sel};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      logic [9:0]  keep;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: reset state
      chk("R9 settings after reset", settings(), 10'd0);
      xfer(8'h66, 16'h0000, 16, rd);
      chk("R9 status after reset", rd, 16'h0002);

      // vector table: R1 R2 R5 and R4 muxes
      foreach (VEC[v]) begin
         xfer(8'h65, VEC[v][25:10], 16, rd);
         chk("R2 R5 settings from write", settings(), VEC[v][9:0]);
         for (int p = 0; p < 2; p++) begin
            src_in = (p == 0) ? 6'h3F : 6'h2A;
            @(negedge clk);
            chk("R4 demod mux", demod_in, pick(src_in, VEC[v][2:0]));
            chk("R4 pass1 mux", pass1_out, pick(src_in, VEC[v][5:3]));
            chk("R4 pass2 mux", pass2_out, pick(src_in, VEC[v][8:6]));
         end
         chk("R10 dout idle after write", ser_dout, 1'b0);
      end

      // R4: each single source routed
      xfer(8'h65, 16'h0000, 16, rd);
      for (int c = 0; c < 6; c++) begin
         xfer(8'h65, 16'(c) << 5, 16, rd);
         src_in = 6'(1) << c;
         @(negedge clk);
         chk("R4 single source routed", demod_in, 1'b1);
         src_in = ~(6'(1) << c);
         @(negedge clk);
         chk("R4 other sources blocked", demod_in, 1'b0);
      end
      xfer(8'h65, 16'h2AE0, 16, rd);
      keep = settings();

      // R1: unknown address ignored
      xfer(8'h64, 16'hFEBF, 16, rd);
      chk("R1 bad address no effect", settings(), keep);
      chk("R1 bad address dout low", rd, 16'h0000);
      xfer(8'hE5, 16'h4460, 16, rd);
      chk("R1 near-miss address no effect", settings(), keep);

      // R3: wrong lengths discarded
      xfer(8'h65, 16'h4460, 15, rd);
      chk("R3 short write discarded", settings(), keep);
      xfer(8'h65, 16'h4460, 17, rd);
      chk("R3 long write discarded", settings(), keep);

      // R6 R7: status read while locked
      st_rate = 2'b10; st_copy = 1'b1; st_cs0 = 1'b0; st_cat = 8'hA5;
      locked  = 1'b1;
      repeat (3) @(negedge clk);
      xfer(8'h66, 16'hFFFF, 16, rd);
      chk("R6 R7 status 48k", rd, stat_exp(2'b10, 1'b1, 1'b0, 8'hA5));
      chk("R1 read leaves settings", settings(), keep);
      st_rate = 2'b11; st_copy = 1'b0; st_cs0 = 1'b1; st_cat = 8'h3C;
      repeat (3) @(negedge clk);
      xfer(8'h66, 16'h0000, 16, rd);
      chk("R6 R7 status 32k", rd, stat_exp(2'b11, 1'b0, 1'b1, 8'h3C));
      st_rate = 2'b00; st_cat = 8'h81;
      repeat (3) @(negedge clk);
      xfer(8'h66, 16'h0000, 16, rd);
      chk("R7 status 44.1k", rd, stat_exp(2'b00, 1'b0, 1'b1, 8'h81));
      chk("R10 dout idle after read", ser_dout, 1'b0);

      // R8: lock lost clears status
      locked = 1'b0;
      repeat (3) @(negedge clk);
      xfer(8'h66, 16'h0000, 16, rd);
      chk("R8 unlocked status cleared", rd, 16'h0002);

      // R9: reset mid-life
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R9 settings cleared by reset", settings(), 10'd0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule